// File: doc/BRIEF.md
# I2S Bit-Clock and Frame-Sync Generator

This block derives the serial bit clock and the word-select / frame-sync line of an I2S or TDM audio link from a faster reference clock. It can also drive a master clock at half the reference rate. The bit clock runs at the reference rate divided by 2×(DIV+1). Every frame is built from a run-time choice of slot width (8, 16, 24 or 32 bit clocks) and slot count (1 to 2^NSLOT_W). The frame-sync line is either a half-frame word select (left channel low, right channel high), a pulse one slot wide, or a pulse one bit clock wide.

Serializers attach to a set of strobes. A one-cycle bit strobe marks the start of every bit period and names the data bit to drive: its index within the slot (0 is the MSB) and the slot number. A slot-start strobe marks bit 0 of each slot. A one-bit data delay moves the data one bit clock behind the frame-sync edge. In controller mode the clocks run unchanged, but the serializer enable and all strobes stay low. The configuration is captured when the generator is enabled and again at every frame boundary, so a frame never mixes two settings.

Top module: `i2s_clkgen`

## Requirements
- R1: While reset is asserted, and while `enable` is low, `sck`, `fs`, `mclk`, `ser_en`, `bit_strobe` and `slot_start` are all 0.
- R2: While running, `sck` is low for DIV+1 reference cycles and then high for DIV+1 reference cycles. The first low phase starts in the cycle after `enable` is first sampled high.
- R3: `slot_size` code c gives 8×(c+1) bit periods per slot (0=8, 1=16, 2=24, 3=32). `nslots_m1` code n gives n+1 slots per frame.
- R4: With `fs_width` code 1, or the alternate code 3, `fs` is low for the first half of the frame's bit periods and high for the second half. A frame started by enabling therefore begins with `fs` low.
- R5: With `fs_width` code 0, `fs` is high only during the first slot of each frame. With code 2, it is high only during the first bit period of each frame.
- R6: `fs` changes only together with a falling edge of `sck`, or when the generator starts or stops.
- R7: `bit_strobe` is high for one reference cycle at the start of every bit period, together with `bit_idx` (0 = MSB) and `slot_idx`. With `bit_delay`=0, frame bit period p carries data bit p. With `bit_delay`=1, it carries data bit p−1, and period 0 carries the last bit of the last slot.
- R8: `slot_start` is high exactly when `bit_strobe` is high and `bit_idx` is 0.
- R9: With `ctrl_mode`=1 (controller mode), `sck` and `fs` run as in master mode, but `ser_en`, `bit_strobe` and `slot_start` stay 0. With `ctrl_mode`=0, `ser_en` is 1 while running.
- R10: `div`, `slot_size`, `nslots_m1`, `bit_delay`, `fs_width` and `ctrl_mode` are captured only when the generator is enabled and at the falling `sck` edge that ends the last bit period of a frame. Changes made at any other time have no effect until then.
- R11: `mclk` toggles on every reference cycle while `enable` and `mclk_on` were both high at the previous edge. Otherwise `mclk` is 0.
- R12: When `enable` is sampled low, all outputs return to 0 in the next cycle. Re-enabling starts a fresh frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator |
| ctrl_mode | input | 1 | 1 = clocks only, serializers held off |
| mclk_on | input | 1 | Drive the master clock |
| div | input | DIV_W (8) | Bit-clock divider; bit clock = clk / (2×(div+1)) |
| slot_size | input | 2 | Slot width code (8×(code+1) bits) |
| nslots_m1 | input | NSLOT_W (3) | Slots per frame minus one |
| bit_delay | input | 1 | Data delay from frame sync (0 or 1 bit) |
| fs_width | input | 2 | 0 one slot, 1/3 half frame, 2 one bit |
| sck | output | 1 | Serial bit clock |
| fs | output | 1 | Word select / frame sync |
| mclk | output | 1 | Master clock (clk/2) |
| ser_en | output | 1 | Serializer enable |
| bit_strobe | output | 1 | Start of a bit period with data to drive |
| slot_start | output | 1 | Start of bit 0 of a slot |
| bit_idx | output | 5 | Data bit index within the slot, 0 = MSB |
| slot_idx | output | NSLOT_W (3) | Slot number of the data bit |

## Verification
The bench targets the frame boundary under a one-bit delay. There, period 0 must carry the last bit of the last slot; a design that restarted the data counters at the frame-sync edge would drive the MSB one bit early and misreport `slot_start`. It also changes the configuration in the middle of a frame, including the divider and the slot count. A design that applied the new settings at once would cut the frame short, move the `fs` edges and shift `bit_idx`. Finally, it drops `enable` mid-frame, uses the alternate half-frame code, and switches to controller mode. A wrong design there would leave `fs` or strobes stuck high, start the next frame with `fs` high, or keep driving serializers while only clocks should run.

// File: rtl/i2s_clkgen_pkg.sv
package i2s_clkgen_pkg;

    // width of the in-slot bit index (slots hold at most 32 bits)
    localparam int SLOT_IDX_W = 5;

    typedef enum logic [1:0] {
        SLOT_8B  = 2'd0,
        SLOT_16B = 2'd1,
        SLOT_24B = 2'd2,
        SLOT_32B = 2'd3
    } slot_code_e;

    typedef enum logic [1:0] {
        FSW_ONE_SLOT = 2'd0,
        FSW_HALF     = 2'd1,
        FSW_ONE_BIT  = 2'd2,
        FSW_HALF_ALT = 2'd3
    } fsw_e;

    typedef struct packed {
        slot_code_e slot;
        fsw_e       fsw;
        logic       ctrl;
    } frame_cfg_t;

endpackage

// File: rtl/i2s_bitclk_div.sv
module i2s_bitclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] div_i,
    output logic             sck_o,
    output logic             start_o,
    output logic             fall_o
);

    typedef struct packed {
        logic             run;
        logic             sck;
        logic [DIV_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;
    logic       at_limit;

    always_comb begin
        at_limit = (st_q.cnt == div_i);
        start_o  = enable && !st_q.run;
        fall_o   = enable && st_q.run && st_q.sck && at_limit;
        st_d     = st_q;
        if (!enable) begin
            st_d = '0;
        end else if (start_o) begin
            st_d.run = 1'b1;
            st_d.sck = 1'b0;
            st_d.cnt = '0;
        end else if (at_limit) begin
            st_d.cnt = '0;
            st_d.sck = !st_q.sck;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sck_o = st_q.sck;

endmodule

// File: rtl/i2s_frame_ctr.sv
module i2s_frame_ctr
    import i2s_clkgen_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int NSLOT_W = 3,
    parameter int FRAME_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               start_i,
    input  logic               fall_i,
    input  frame_cfg_t         cfg_i,
    input  logic [NSLOT_W-1:0] nslots_i,
    input  logic [DIV_W-1:0]   div_i,
    output slot_code_e         slot_q_o,
    output logic               ctrl_q_o,
    output logic [NSLOT_W-1:0] nslots_q_o,
    output logic [DIV_W-1:0]   div_q_o,
    output logic               load_o,
    output logic               fs_o,
    output logic               ser_en_o
);

    typedef struct packed {
        frame_cfg_t         cfg;
        logic [NSLOT_W-1:0] nslots;
        logic [DIV_W-1:0]   div;
        logic [FRAME_W-1:0] fbit;
        logic               fs;
        logic               ser_en;
    } frame_state_t;

    frame_state_t       st_d, st_q;
    logic [FRAME_W-1:0] slot_len, frame_len, fbit_nxt;
    logic               last_period;

    always_comb begin
        slot_len    = FRAME_W'({st_q.cfg.slot, 3'b000}) + FRAME_W'(8);
        frame_len   = slot_len * (FRAME_W'(st_q.nslots) + FRAME_W'(1));
        last_period = (st_q.fbit == frame_len - FRAME_W'(1));
        fbit_nxt    = st_q.fbit + FRAME_W'(1);
        load_o      = start_i || (fall_i && last_period);
        st_d        = st_q;
        if (!enable) begin
            st_d = '0;
        end else if (load_o) begin
            // frame boundary: capture settings, restart the frame count
            st_d.cfg    = cfg_i;
            st_d.nslots = nslots_i;
            st_d.div    = div_i;
            st_d.fbit   = '0;
            st_d.fs     = (cfg_i.fsw == FSW_ONE_SLOT) || (cfg_i.fsw == FSW_ONE_BIT);
            st_d.ser_en = !cfg_i.ctrl;
        end else if (fall_i) begin
            st_d.fbit = fbit_nxt;
            case (st_q.cfg.fsw)
                FSW_ONE_SLOT: st_d.fs = (fbit_nxt < slot_len);
                FSW_ONE_BIT:  st_d.fs = 1'b0;
                default:      st_d.fs = ({fbit_nxt, 1'b0} >= {1'b0, frame_len});
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot_q_o   = st_q.cfg.slot;
    assign ctrl_q_o   = st_q.cfg.ctrl;
    assign nslots_q_o = st_q.nslots;
    assign div_q_o    = st_q.div;
    assign fs_o       = st_q.fs;
    assign ser_en_o   = st_q.ser_en;

endmodule

// File: rtl/i2s_slot_track.sv
module i2s_slot_track
    import i2s_clkgen_pkg::*;
#(
    parameter int NSLOT_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  load_i,
    input  logic                  fall_i,
    input  slot_code_e            slot_live_i,
    input  logic                  delay_live_i,
    input  logic                  ctrl_live_i,
    input  logic [NSLOT_W-1:0]    nslots_live_i,
    input  slot_code_e            slot_q_i,
    input  logic                  ctrl_q_i,
    input  logic [NSLOT_W-1:0]    nslots_q_i,
    output logic [SLOT_IDX_W-1:0] bit_idx_o,
    output logic [NSLOT_W-1:0]    slot_idx_o,
    output logic                  bit_strobe_o,
    output logic                  slot_start_o
);

    typedef struct packed {
        logic [SLOT_IDX_W-1:0] dbit;
        logic [NSLOT_W-1:0]    dslot;
        logic                  strobe;
        logic                  sstart;
    } track_state_t;

    track_state_t          st_d, st_q;
    logic [SLOT_IDX_W-1:0] last_live, last_q;
    logic                  slot_end;

    always_comb begin
        last_live = {slot_live_i, 3'b111};
        last_q    = {slot_q_i, 3'b111};
        slot_end  = (st_q.dbit == last_q);
        st_d        = st_q;
        st_d.strobe = 1'b0;
        st_d.sstart = 1'b0;
        if (!enable) begin
            st_d = '0;
        end else if (load_i) begin
            if (delay_live_i) begin
                // period 0 still carries the final bit of the previous frame
                st_d.dbit  = last_live;
                st_d.dslot = nslots_live_i;
            end else begin
                st_d.dbit  = '0;
                st_d.dslot = '0;
            end
            st_d.strobe = !ctrl_live_i;
            st_d.sstart = !ctrl_live_i && !delay_live_i;
        end else if (fall_i) begin
            if (slot_end) begin
                st_d.dbit  = '0;
                st_d.dslot = (st_q.dslot == nslots_q_i) ? '0 : st_q.dslot + NSLOT_W'(1);
            end else begin
                st_d.dbit = st_q.dbit + SLOT_IDX_W'(1);
            end
            st_d.strobe = !ctrl_q_i;
            st_d.sstart = !ctrl_q_i && slot_end;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_idx_o    = st_q.dbit;
    assign slot_idx_o   = st_q.dslot;
    assign bit_strobe_o = st_q.strobe;
    assign slot_start_o = st_q.sstart;

endmodule

// File: rtl/i2s_mclk_gen.sv
module i2s_mclk_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic mclk_on,
    output logic mclk_o
);

    logic mclk_d, mclk_q;

    always_comb begin
        mclk_d = (enable && mclk_on) ? !mclk_q : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mclk_q <= 1'b0;
        else        mclk_q <= mclk_d;
    end

    assign mclk_o = mclk_q;

endmodule

// File: rtl/i2s_clkgen.sv
module i2s_clkgen
    import i2s_clkgen_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int NSLOT_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  ctrl_mode,
    input  logic                  mclk_on,
    input  logic [DIV_W-1:0]      div,
    input  logic [1:0]            slot_size,
    input  logic [NSLOT_W-1:0]    nslots_m1,
    input  logic                  bit_delay,
    input  logic [1:0]            fs_width,
    output logic                  sck,
    output logic                  fs,
    output logic                  mclk,
    output logic                  ser_en,
    output logic                  bit_strobe,
    output logic                  slot_start,
    output logic [SLOT_IDX_W-1:0] bit_idx,
    output logic [NSLOT_W-1:0]    slot_idx
);

    localparam int FRAME_W = SLOT_IDX_W + NSLOT_W + 1;

    frame_cfg_t         cfg_live;
    slot_code_e         slot_q;
    logic               ctrl_q;
    logic [NSLOT_W-1:0] nslots_q;
    logic [DIV_W-1:0]   div_q;
    logic               start, fall, load;

    assign cfg_live = '{slot: slot_code_e'(slot_size), fsw: fsw_e'(fs_width), ctrl: ctrl_mode};

    i2s_bitclk_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .div_i   (div_q),
        .sck_o   (sck),
        .start_o (start),
        .fall_o  (fall)
    );

    i2s_frame_ctr #(.DIV_W(DIV_W), .NSLOT_W(NSLOT_W), .FRAME_W(FRAME_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .start_i    (start),
        .fall_i     (fall),
        .cfg_i      (cfg_live),
        .nslots_i   (nslots_m1),
        .div_i      (div),
        .slot_q_o   (slot_q),
        .ctrl_q_o   (ctrl_q),
        .nslots_q_o (nslots_q),
        .div_q_o    (div_q),
        .load_o     (load),
        .fs_o       (fs),
        .ser_en_o   (ser_en)
    );

    i2s_slot_track #(.NSLOT_W(NSLOT_W)) u_track (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .load_i        (load),
        .fall_i        (fall),
        .slot_live_i   (cfg_live.slot),
        .delay_live_i  (bit_delay),
        .ctrl_live_i   (ctrl_mode),
        .nslots_live_i (nslots_m1),
        .slot_q_i      (slot_q),
        .ctrl_q_i      (ctrl_q),
        .nslots_q_i    (nslots_q),
        .bit_idx_o     (bit_idx),
        .slot_idx_o    (slot_idx),
        .bit_strobe_o  (bit_strobe),
        .slot_start_o  (slot_start)
    );

    i2s_mclk_gen u_mclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .mclk_on (mclk_on),
        .mclk_o  (mclk)
    );

endmodule

// File: rtl/i2s_clkgen_chk.sv
module i2s_clkgen_chk
    import i2s_clkgen_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  enable,
    input logic                  mclk_on,
    input logic                  sck,
    input logic                  fs,
    input logic                  mclk,
    input logic                  ser_en,
    input logic                  bit_strobe,
    input logic                  slot_start,
    input logic [SLOT_IDX_W-1:0] bit_idx
);

    p_idle_after_disable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!sck && !fs && !ser_en && !bit_strobe && !slot_start && !mclk));

    p_fs_moves_with_low_sck_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fs != $past(fs)) |-> !sck);

    p_strobe_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_strobe && $past(ser_en)) |-> ($past(sck) && !sck));

    p_slot_start_is_msb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        slot_start |-> (bit_strobe && (bit_idx == '0)));

    p_quiet_without_ser_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en |-> (!bit_strobe && !slot_start));

    p_mclk_toggles_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(enable && mclk_on) |-> (mclk != $past(mclk)));

    p_mclk_parked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable && mclk_on) |-> !mclk);

endmodule

bind i2s_clkgen i2s_clkgen_chk u_chk (.*);

// File: tb/i2s_clkgen_bench.sv
module i2s_clkgen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       enable = 1'b0;
    logic       ctrl_mode = 1'b0;
    logic       mclk_on = 1'b0;
    logic [7:0] div = '0;
    logic [1:0] slot_size = '0;
    logic [2:0] nslots_m1 = '0;
    logic       bit_delay = 1'b0;
    logic [1:0] fs_width = '0;
    logic       sck, fs, mclk, ser_en, bit_strobe, slot_start;
    logic [4:0] bit_idx;
    logic [2:0] slot_idx;

    always #2 clk = !clk;

    i2s_clkgen u_i2s_clkgen (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ctrl_mode(ctrl_mode),
        .mclk_on(mclk_on), .div(div), .slot_size(slot_size), .nslots_m1(nslots_m1),
        .bit_delay(bit_delay), .fs_width(fs_width), .sck(sck), .fs(fs), .mclk(mclk),
        .ser_en(ser_en), .bit_strobe(bit_strobe), .slot_start(slot_start),
        .bit_idx(bit_idx), .slot_idx(slot_idx)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string ctx = "R1 reset";

    // reference model, built from the requirements
    bit m_run, m_sck, m_strobe, m_mclk;
    int m_cnt, m_p;
    int m_div, m_slot, m_ns, m_delay, m_fsw, m_ctrl;

    function automatic int sbits(int code);
        return 8 * (code + 1);
    endfunction

    function automatic int flen(int code, int ns);
        return sbits(code) * (ns + 1);
    endfunction

    function automatic bit fs_exp(int p, int code, int ns, int fsw);
        if (fsw == 0) return p < sbits(code);
        if (fsw == 2) return p == 0;
        return 2 * p >= flen(code, ns);
    endfunction

    task automatic latch_cfg();
        m_div = div; m_slot = slot_size; m_ns = nslots_m1;
        m_delay = bit_delay; m_fsw = fs_width; m_ctrl = ctrl_mode;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_cnt = 0; m_sck = 0; m_p = 0; m_strobe = 0; m_mclk = 0;
        end else begin
            m_mclk = (enable && mclk_on) ? !m_mclk : 1'b0;
            if (!enable) begin
                m_run = 0; m_cnt = 0; m_sck = 0; m_p = 0; m_strobe = 0;
            end else if (!m_run) begin
                m_run = 1; latch_cfg(); m_cnt = 0; m_sck = 0; m_p = 0; m_strobe = 1;
            end else if (m_cnt == m_div) begin
                m_cnt = 0;
                if (m_sck) begin
                    m_sck = 0; m_strobe = 1;
                    if (m_p == flen(m_slot, m_ns) - 1) begin
                        latch_cfg(); m_p = 0;
                    end else begin
                        m_p++;
                    end
                end else begin
                    m_sck = 1; m_strobe = 0;
                end
            end else begin
                m_cnt++; m_strobe = 0;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", tag, ctx, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            chk("R11 mclk", mclk, m_mclk);
            if (!m_run) begin
                chk("R1 R12 idle sck", sck, 0);
                chk("R1 R12 idle fs", fs, 0);
                chk("R1 R12 idle ser_en", ser_en, 0);
                chk("R1 R12 idle bit_strobe", bit_strobe, 0);
                chk("R1 R12 idle slot_start", slot_start, 0);
            end else begin
                int  d, sb;
                bit  es;
                sb = sbits(m_slot);
                es = m_strobe && (m_ctrl == 0);
                d  = m_p - m_delay;
                if (d < 0) d += flen(m_slot, m_ns);
                chk("R2 sck", sck, m_sck);
                chk("R4 R5 R6 fs", fs, fs_exp(m_p, m_slot, m_ns, m_fsw));
                chk("R9 ser_en", ser_en, m_ctrl == 0);
                chk("R7 R9 bit_strobe", bit_strobe, es);
                chk("R8 slot_start", slot_start, es && (d % sb == 0));
                if (es) begin
                    chk("R3 R7 bit_idx", bit_idx, d % sb);
                    chk("R3 R7 slot_idx", slot_idx, d / sb);
                end
            end
        end
    end

    task automatic set_cfg(int dv, int sz, int ns, int dl, int fw, int cm, int mo);
        div = 8'(dv); slot_size = 2'(sz); nslots_m1 = 3'(ns);
        bit_delay = dl[0]; fs_width = 2'(fw); ctrl_mode = cm[0]; mclk_on = mo[0];
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int fcyc();
        return flen(int'(slot_size), int'(nslots_m1)) * 2 * (int'(div) + 1);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired [%s] actual=%0d expected=%0d", ctx, 1, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        #1 rst_n = 1'b0;
        chk_on = 1'b1;
        ctx = "R1 reset";
        wait_cyc(6);
        rst_n = 1'b1;
        wait_cyc(4);

        ctx = "R4 16-bit stereo delay 1";
        set_cfg(1, 1, 1, 1, 1, 0, 1);
        enable = 1'b1;
        wait_cyc(3 * fcyc());

        ctx = "R12 disable";
        enable = 1'b0;
        wait_cyc(3);
        ctx = "R3 24-bit stereo";
        set_cfg(0, 2, 1, 1, 1, 0, 0);
        enable = 1'b1;
        wait_cyc(2 * fcyc() + 5);

        enable = 1'b0;
        wait_cyc(2);
        ctx = "R5 one-bit sync, one 8-bit slot";
        set_cfg(0, 0, 0, 0, 2, 0, 1);
        enable = 1'b1;
        wait_cyc(4 * fcyc());

        enable = 1'b0;
        wait_cyc(2);
        ctx = "R5 one-slot sync, eight 32-bit slots";
        set_cfg(0, 3, 7, 0, 0, 0, 0);
        enable = 1'b1;
        wait_cyc(2 * fcyc());

        enable = 1'b0;
        wait_cyc(2);
        ctx = "R9 controller, alternate half code";
        set_cfg(2, 1, 1, 1, 3, 1, 1);
        enable = 1'b1;
        wait_cyc(fcyc() + fcyc() / 2);

        ctx = "R10 change in mid frame";
        set_cfg(0, 0, 3, 0, 1, 0, 1);
        wait_cyc(600);

        ctx = "R12 drop in mid frame";
        wait_cyc(37);
        enable = 1'b0;
        wait_cyc(2);
        enable = 1'b1;
        wait_cyc(3 * fcyc());

        for (int i = 0; i < 40; i++) begin
            ctx = "R10 random settings";
            if (i % 5 == 0) begin
                enable = 1'b0;
                wait_cyc($urandom_range(1, 3));
            end
            set_cfg($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                    $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 3) == 0,
                    $urandom_range(0, 1));
            enable = 1'b1;
            wait_cyc(2 * fcyc() + $urandom_range(0, 50));
        end

        enable = 1'b0;
        ctx = "R12 final stop";
        wait_cyc(4);
        finish_run();
    end

endmodule